// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block keeps a 32-bit word of pending interrupt causes and turns changes to it into an interrupt for the host. Two internal completion sources and software can each ask to raise or to lower cause bits with a mask. A raise ORs its mask into the word. A lower clears the bits of its mask. Software uses two write offsets for these requests, and reads the word back at a third offset.

The block signals in one of two ways, chosen by a mode input. In level mode an interrupt line goes high when a raise leaves the word nonzero, and it goes low only when a lower leaves the word at zero. In message mode every raise that leaves the word nonzero gives one single-cycle pulse, and a lower never gives one. This pulse stands for the message write that the bus side sends. Address decoding above the offset field is done outside this block.

Top module: `intr_status_agg`

## Requirements
- R1: While reset is held, and right after it, the status word reads 0 and both `irq_level_o` and `msg_pulse_o` are low.
- R2: A write (`sw_wr_i` high) at offset 0x60 ORs `sw_wdata_i` into the status word. The new value is visible one clock later.
- R3: A write at offset 0x64 clears every status bit that is set in `sw_wdata_i` and leaves the other bits as they were.
- R4: A one-cycle pulse on `calc_done_i` sets status bit 0. A one-cycle pulse on `xfer_done_i` sets status bit 8. Each of these counts as a raise request.
- R5: `rd_data_o` returns the current status word when `rd_addr_i` is 0x24, and returns 0 for any other offset.
- R6: With `msg_en_i` low, a raise that leaves the status nonzero drives `irq_level_o` high from the next clock on.
- R7: With `msg_en_i` low, `irq_level_o` falls only after a lower that leaves the status at zero. A lower that leaves some bit set keeps the line high. A lower with mask 0 on a zero status also drops the line.
- R8: With `msg_en_i` high, every raise that leaves the status nonzero gives `msg_pulse_o` high for exactly one clock. This includes a raise with mask 0 while bits are already pending. A raise that leaves the status at zero gives no pulse.
- R9: With `msg_en_i` high, a lower produces no pulse and does not change `irq_level_o`, even when the status becomes zero.
- R10: When a raise and a software lower arrive in the same cycle, the lower is applied first and the raise second, so a bit that is both raised and cleared stays set and is signalled.
- R11: Writes to any offset other than 0x60 and 0x64 change neither the status nor the outputs.
- R12: In level mode `msg_pulse_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| msg_en_i | input | 1 | 1 selects message mode, 0 selects level mode |
| calc_done_i | input | 1 | Computation-complete source, raises bit 0 |
| xfer_done_i | input | 1 | Transfer-complete source, raises bit 8 |
| sw_wr_i | input | 1 | Software write strobe |
| sw_addr_i | input | 8 | Software write offset |
| sw_wdata_i | input | 32 | Software write data, used as the raise or lower mask |
| rd_addr_i | input | 8 | Read offset |
| rd_data_o | output | 32 | Read data |
| irq_level_o | output | 1 | Level interrupt line |
| msg_pulse_o | output | 1 | One-cycle message-interrupt request |

## Verification
The bench looks at the edges between the two modes. A lower that leaves one bit set must keep the line high. A design that drops the line on any lower fails here. A level line raised in level mode must stay high through a full clear made in message mode. A design that releases it there, or that pulses on a lower, fails this case. A raise with mask 0 must pulse in message mode only when bits are pending, and it must leave the line untouched in level mode. A raise on bit 0 that meets a software clear of bit 0 in the same cycle must keep the bit set. A design that applies the clear last loses that event, and the status and line checks report it.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int unsigned DEF_STATUS_W  = 32;
  localparam int unsigned DEF_ADDR_W    = 8;
  localparam int unsigned DEF_STAT_OFS  = 'h24;
  localparam int unsigned DEF_RAISE_OFS = 'h60;
  localparam int unsigned DEF_LOWER_OFS = 'h64;
  localparam int unsigned DEF_CALC_BIT  = 0;
  localparam int unsigned DEF_XFER_BIT  = 8;

  typedef enum logic [1:0] {
    SIG_LEVEL_HOLD,
    SIG_LEVEL_SET,
    SIG_LEVEL_CLR
  } level_act_e;
endpackage

// File: rtl/intr_req_decode.sv
module intr_req_decode
  import intr_agg_pkg::*;
#(
  parameter int unsigned STATUS_W  = DEF_STATUS_W,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned RAISE_OFS = DEF_RAISE_OFS,
  parameter int unsigned LOWER_OFS = DEF_LOWER_OFS,
  parameter int unsigned CALC_BIT  = DEF_CALC_BIT,
  parameter int unsigned XFER_BIT  = DEF_XFER_BIT
) (
  input  logic                calc_done_i,
  input  logic                xfer_done_i,
  input  logic                sw_wr_i,
  input  logic [ADDR_W-1:0]   sw_addr_i,
  input  logic [STATUS_W-1:0] sw_wdata_i,
  output logic                raise_v_o,
  output logic [STATUS_W-1:0] raise_mask_o,
  output logic                lower_v_o,
  output logic [STATUS_W-1:0] lower_mask_o
);
  localparam logic [ADDR_W-1:0] RaiseAddr = ADDR_W'(RAISE_OFS);
  localparam logic [ADDR_W-1:0] LowerAddr = ADDR_W'(LOWER_OFS);

  logic                sw_raise, sw_lower;
  logic [STATUS_W-1:0] hw_mask;

  assign sw_raise = sw_wr_i && (sw_addr_i == RaiseAddr);
  assign sw_lower = sw_wr_i && (sw_addr_i == LowerAddr);

  // one-hot position of each hardware source in the status word
  for (genvar b = 0; b < STATUS_W; b++) begin : g_hw_map
    if (b == CALC_BIT && b == XFER_BIT) begin : g_both
      assign hw_mask[b] = calc_done_i | xfer_done_i;
    end else if (b == CALC_BIT) begin : g_calc
      assign hw_mask[b] = calc_done_i;
    end else if (b == XFER_BIT) begin : g_xfer
      assign hw_mask[b] = xfer_done_i;
    end else begin : g_none
      assign hw_mask[b] = 1'b0;
    end
  end

  assign raise_v_o    = sw_raise | calc_done_i | xfer_done_i;
  assign raise_mask_o = (sw_raise ? sw_wdata_i : '0) | hw_mask;
  assign lower_v_o    = sw_lower;
  assign lower_mask_o = sw_lower ? sw_wdata_i : '0;
endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg
  import intr_agg_pkg::*;
#(
  parameter int unsigned STATUS_W = DEF_STATUS_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                raise_v_i,
  input  logic [STATUS_W-1:0] raise_mask_i,
  input  logic                lower_v_i,
  input  logic [STATUS_W-1:0] lower_mask_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [STATUS_W-1:0] after_lower_o,
  output logic [STATUS_W-1:0] status_next_o
);
  logic [STATUS_W-1:0] status_q;

  // lower first, then raise: a same-cycle event survives a clear
  assign after_lower_o = lower_v_i ? (status_q & ~lower_mask_i) : status_q;
  assign status_next_o = raise_v_i ? (after_lower_o | raise_mask_i) : after_lower_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_next_o;
  end

  assign status_o = status_q;

  assert_raise_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_v_i |=> ((status_q & $past(raise_mask_i)) == $past(raise_mask_i)));

  assert_lower_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lower_v_i && !raise_v_i) |=> ((status_q & $past(lower_mask_i)) == '0));

  assert_idle_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lower_v_i && !raise_v_i) |=> $stable(status_q));
endmodule

// File: rtl/intr_signal_ctrl.sv
module intr_signal_ctrl
  import intr_agg_pkg::*;
#(
  parameter int unsigned STATUS_W = DEF_STATUS_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                msg_en_i,
  input  logic                raise_v_i,
  input  logic                lower_v_i,
  input  logic [STATUS_W-1:0] after_lower_i,
  input  logic [STATUS_W-1:0] status_next_i,
  output logic                level_o,
  output logic                pulse_o
);
  level_act_e level_act;
  logic       level_q, pulse_q, fire;

  assign fire = raise_v_i && (status_next_i != '0);

  always_comb begin
    level_act = SIG_LEVEL_HOLD;
    if (!msg_en_i) begin
      if (fire)                                     level_act = SIG_LEVEL_SET;
      else if (lower_v_i && (after_lower_i == '0))  level_act = SIG_LEVEL_CLR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire && msg_en_i;
      case (level_act)
        SIG_LEVEL_SET: level_q <= 1'b1;
        SIG_LEVEL_CLR: level_q <= 1'b0;
        default:       level_q <= level_q;
      endcase
    end
  end

  assign level_o = level_q;
  assign pulse_o = pulse_q;

  assert_msg_fires_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_en_i && raise_v_i && (status_next_i != '0)) |=> pulse_q);

  assert_lower_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_en_i && lower_v_i && !raise_v_i) |=> (!pulse_q && $stable(level_q)));

  assert_no_pulse_level_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_en_i |=> !pulse_q);
endmodule

// File: rtl/intr_status_agg.sv
module intr_status_agg
  import intr_agg_pkg::*;
#(
  parameter int unsigned STATUS_W  = DEF_STATUS_W,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned STAT_OFS  = DEF_STAT_OFS,
  parameter int unsigned RAISE_OFS = DEF_RAISE_OFS,
  parameter int unsigned LOWER_OFS = DEF_LOWER_OFS,
  parameter int unsigned CALC_BIT  = DEF_CALC_BIT,
  parameter int unsigned XFER_BIT  = DEF_XFER_BIT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                msg_en_i,
  input  logic                calc_done_i,
  input  logic                xfer_done_i,
  input  logic                sw_wr_i,
  input  logic [ADDR_W-1:0]   sw_addr_i,
  input  logic [STATUS_W-1:0] sw_wdata_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [STATUS_W-1:0] rd_data_o,
  output logic                irq_level_o,
  output logic                msg_pulse_o
);
  localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_OFS);

  logic                raise_v, lower_v;
  logic [STATUS_W-1:0] raise_mask, lower_mask, status, after_lower, status_next;

  intr_req_decode #(
    .STATUS_W(STATUS_W), .ADDR_W(ADDR_W), .RAISE_OFS(RAISE_OFS),
    .LOWER_OFS(LOWER_OFS), .CALC_BIT(CALC_BIT), .XFER_BIT(XFER_BIT)
  ) u_decode (
    .calc_done_i (calc_done_i),
    .xfer_done_i (xfer_done_i),
    .sw_wr_i     (sw_wr_i),
    .sw_addr_i   (sw_addr_i),
    .sw_wdata_i  (sw_wdata_i),
    .raise_v_o   (raise_v),
    .raise_mask_o(raise_mask),
    .lower_v_o   (lower_v),
    .lower_mask_o(lower_mask)
  );

  intr_status_reg #(.STATUS_W(STATUS_W)) u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .raise_v_i    (raise_v),
    .raise_mask_i (raise_mask),
    .lower_v_i    (lower_v),
    .lower_mask_i (lower_mask),
    .status_o     (status),
    .after_lower_o(after_lower),
    .status_next_o(status_next)
  );

  intr_signal_ctrl #(.STATUS_W(STATUS_W)) u_signal (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .msg_en_i     (msg_en_i),
    .raise_v_i    (raise_v),
    .lower_v_i    (lower_v),
    .after_lower_i(after_lower),
    .status_next_i(status_next),
    .level_o      (irq_level_o),
    .pulse_o      (msg_pulse_o)
  );

  assign rd_data_o = (rd_addr_i == StatAddr) ? status : '0;

  assert_level_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_level_o) |-> (status != '0));

  assert_level_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_level_o) |-> (status == '0));

  assert_pulse_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_pulse_o |-> (status != '0));
endmodule

// File: tb/tb_intr_status_agg.sv
`timescale 1ns/100ps
module tb_intr_status_agg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_en = 1'b0, calc = 1'b0, xfer = 1'b0, sw_wr = 1'b0;
  logic [7:0]  sw_addr = '0, rd_addr = 8'h24;
  logic [31:0] sw_wdata = '0, rd_data;
  logic        level, pulse;

  int total = 0, failed = 0;

  typedef struct {
    string       tag;
    logic [31:0] st;
    logic        lvl;
    logic        pls;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  logic [31:0] m_st = '0;
  logic        m_lvl = 1'b0;

  always #2 clk = ~clk;

  intr_status_agg dut (
    .clk_i(clk), .rst_ni(rst_ni), .msg_en_i(msg_en), .calc_done_i(calc),
    .xfer_done_i(xfer), .sw_wr_i(sw_wr), .sw_addr_i(sw_addr),
    .sw_wdata_i(sw_wdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_level_o(level), .msg_pulse_o(pulse)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected outcome pushed for the monitor
  task automatic step(logic wr, logic [7:0] a, logic [31:0] d, logic c, logic x,
                      logic me, string tag);
    logic [31:0] rm, s1, s2;
    logic        rv, lv, pl;
    @(negedge clk);
    sw_wr = wr; sw_addr = a; sw_wdata = d; calc = c; xfer = x; msg_en = me;
    rv = (wr && a == 8'h60) || c || x;
    lv = wr && a == 8'h64;
    rm = ((wr && a == 8'h60) ? d : 32'h0) | {31'h0, c} | (x ? 32'h100 : 32'h0);
    s1 = lv ? (m_st & ~d) : m_st;
    s2 = rv ? (s1 | rm) : s1;
    pl = 1'b0;
    if (lv && s1 == 0 && !me) m_lvl = 1'b0;
    if (rv && s2 != 0) begin
      if (me) pl = 1'b1;
      else    m_lvl = 1'b1;
    end
    m_st = s2;
    q.push_back('{tag, s2, m_lvl, pl});
  endtask

  task automatic idle(logic me, string tag);
    step(1'b0, 8'h00, 32'h0, 1'b0, 1'b0, me, tag);
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      chk(cur.tag, "status", rd_data, cur.st);
      chk(cur.tag, "level", {31'h0, level}, {31'h0, cur.lvl});
      chk(cur.tag, "pulse", {31'h0, pulse}, {31'h0, cur.pls});
    end
  end

  initial begin
    #400000;
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", rd_data, 32'h0);
    chk("R1", "level in reset", {31'h0, level}, 32'h0);
    chk("R1", "pulse in reset", {31'h0, pulse}, 32'h0);
    rst_ni = 1'b1;
    idle(1'b0, "R1 after reset");

    // level mode
    step(1'b1, 8'h60, 32'h0000_0005, 1'b0, 1'b0, 1'b0, "R2 R6 sw raise");
    idle(1'b0, "R12 hold");
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b0, "R4 calc bit0");
    step(1'b0, 8'h00, 32'h0, 1'b0, 1'b1, 1'b0, "R4 xfer bit8");
    step(1'b1, 8'h64, 32'h0000_0004, 1'b0, 1'b0, 1'b0, "R3 R7 partial lower");
    step(1'b1, 8'h20, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R11 other offset");
    step(1'b1, 8'h64, 32'h0000_0101, 1'b0, 1'b0, 1'b0, "R3 R7 full lower");
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0, 1'b0, "R8 zero raise on zero");
    idle(1'b0, "R7 idle low");

    // level survives a clear made in message mode
    step(1'b1, 8'h60, 32'h0000_0002, 1'b0, 1'b0, 1'b0, "R6 raise");
    step(1'b1, 8'h64, 32'h0000_0002, 1'b0, 1'b0, 1'b1, "R9 lower in msg");
    idle(1'b1, "R9 idle");
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0, 1'b0, "R7 zero raise keeps line");
    step(1'b1, 8'h64, 32'h0, 1'b0, 1'b0, 1'b0, "R7 zero lower on zero");

    // message mode
    step(1'b1, 8'h60, 32'h0000_0010, 1'b0, 1'b0, 1'b1, "R8 msg raise");
    idle(1'b1, "R8 one cycle");
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0, 1'b1, "R8 zero raise pending");
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 1'b1, "R8 R4 calc back to back");
    idle(1'b1, "R8 drop");
    step(1'b1, 8'h64, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, "R9 clear all");
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0, 1'b1, "R8 zero raise empty");

    // same-cycle raise and lower
    step(1'b1, 8'h60, 32'h0000_0001, 1'b0, 1'b0, 1'b0, "R10 setup");
    step(1'b1, 8'h64, 32'h0000_0001, 1'b1, 1'b0, 1'b0, "R10 calc vs lower");
    step(1'b1, 8'h64, 32'h0000_0101, 1'b0, 1'b1, 1'b1, "R10 xfer vs lower msg");
    idle(1'b1, "R10 idle");

    wait (q.size() == 0);
    @(negedge clk);
    rd_addr = 8'h20;
    #0.5;
    chk("R5", "other read offset", rd_data, 32'h0);
    rd_addr = 8'h24;
    #0.5;
    chk("R5", "status read offset", rd_data, m_st);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule